// File: doc/BRIEF.md
# Oversampled Serial Frame Sender with Automatic Retry

This block moves one byte across a noisy single-wire serial link. A sample-rate enable, pulsing at four times the bit rate, paces the line. For each byte the block drives a run of high samples as a start marker and then the data bits, least significant first. Each bit is repeated over several consecutive samples so that the receiver can decide each bit by majority.

After a frame has gone out, the line returns low and the block listens on an acknowledge input for a short window, counted in sample enables. A high acknowledge inside that window completes the transfer. With no acknowledge, the identical frame is sent again. After a fixed number of unanswered attempts the byte is dropped and a one-cycle fail pulse is raised.

A producer hands over bytes through a valid/ready pair. A new byte is taken only while the block is idle.

Top module: `oframe_tx`

## Requirements
- R1: After reset and while idle, `line_out` is low, `in_ready` is high, `busy` is low and `fail` is low. An idle block ignores sample enables.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. From the next cycle until success or failure, `in_ready` is low and `busy` is high. `in_valid` is ignored while busy, and the byte being sent does not change.
- R3: `line_out` changes only on clock edges where `smp_en` is high. The first sample of a frame appears at the first enable after the byte is taken, and the line stays low before that enable.
- R4: Every frame opens with 8 consecutive high samples.
- R5: After the start run come the 8 data bits, bit 0 first and bit 7 last. Each bit is held for exactly 4 samples, and a 1 is driven high.
- R6: Once the last data sample has been sent, the next enable drives the line low. The line then stays low through the acknowledge window.
- R7: The acknowledge window is the 4 enables that follow the enable that drove the line low. If `ack_in` is high on any of those enables, the transfer ends at that edge and the block is idle with no fail pulse.
- R8: `ack_in` has no effect while a frame is being sent or while the block is idle.
- R9: If no acknowledge is seen in the window, the fourth window enable starts the identical frame again, beginning with its first high start sample.
- R10: If the 8th attempt also goes unanswered, the fourth window enable of that attempt returns the block to idle and raises `fail` for exactly one clock cycle.
- R11: If an acknowledge arrives on the fourth window enable of the final attempt, the transfer is a success and no fail pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample-rate enable, four per bit period |
| in_data | input | 8 | Byte offered for sending |
| in_valid | input | 1 | Producer holds a byte |
| in_ready | output | 1 | Block is idle and will take a byte |
| ack_in | input | 1 | Acknowledge from the far end |
| line_out | output | 1 | Serial line output |
| busy | output | 1 | A transfer is in progress |
| fail | output | 1 | One-cycle pulse when a byte is dropped |

## Verification
On the fourth enable of the acknowledge window, two decisions fall on the same clock edge. That edge either completes the transfer or starts the next attempt, and on the final attempt the alternative is the fail pulse. The bench drives `ack_in` high on exactly that enable, both after seven unanswered attempts and in an ordinary transfer. It then judges that edge by reading `busy`, `line_out` and `fail` half a clock after it. A twin run withholds the acknowledge and must instead show a fresh start sample, or the fail pulse on the last attempt.

// File: rtl/oftx_pkg.sv
package oftx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_SEND  = 2'd2,
      ST_WAIT  = 2'd3
   } oftx_state_e;

   function automatic int frame_samples(input int start_len, input int data_w, input int spb);
      return start_len + data_w * spb;
   endfunction

endpackage

// File: rtl/oftx_step_counter.sv
module oftx_step_counter #(
   parameter int LIMIT = 4,
   parameter int W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);

   if (LIMIT < 1 || (LIMIT - 1) >= (1 << W)) begin : g_bad_width
      initial $fatal(1, "oftx_step_counter: W too small for LIMIT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (clr) begin
         value <= '0;
      end else if (inc) begin
         value <= value + W'(1);
      end
   end

endmodule

// File: rtl/oftx_sample_mux.sv
module oftx_sample_mux #(
   parameter int DATA_W          = 8,
   parameter int START_SAMPLES   = 8,
   parameter int SAMPLES_PER_BIT = 4,
   parameter bit LSB_FIRST       = 1'b1,
   parameter int POS_W           = 6
) (
   input  logic [POS_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   output logic              sample
);

   logic [DATA_W-1:0] ordered;
   logic [DATA_W-1:0] hit;
   logic              in_start;

   if (LSB_FIRST) begin : g_lsb_first
      assign ordered = data;
   end else begin : g_msb_first
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign ordered[i] = data[DATA_W-1-i];
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_slot
      localparam int LO = START_SAMPLES + i * SAMPLES_PER_BIT;
      localparam int HI = LO + SAMPLES_PER_BIT;
      assign hit[i] = (idx >= POS_W'(LO)) && (idx < POS_W'(HI));
   end

   assign in_start = (idx < POS_W'(START_SAMPLES));
   assign sample   = in_start | (|(hit & ordered));

endmodule

// File: rtl/oftx_ctrl.sv
module oftx_ctrl
   import oftx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic in_valid,
   input  logic ack_in,
   input  logic pos_last,
   input  logic wait_last,
   input  logic try_last,
   input  logic sample_bit,
   output logic accept,
   output logic start_frame,
   output logic pos_clr,
   output logic pos_inc,
   output logic wait_clr,
   output logic wait_inc,
   output logic try_clr,
   output logic try_inc,
   output logic in_ready,
   output logic busy,
   output logic line_out,
   output logic fail
);

   oftx_state_e st_q, st_d;
   logic        win_edge;
   logic        timeout;
   logic        acked;
   logic        line_d;
   logic        fail_d;

   assign win_edge = smp_en && (st_q == ST_WAIT);
   assign acked    = win_edge && ack_in;
   assign timeout  = win_edge && !ack_in && wait_last;

   assign in_ready    = (st_q == ST_IDLE);
   assign busy        = (st_q != ST_IDLE);
   assign accept      = in_valid && in_ready;
   assign start_frame = (smp_en && (st_q == ST_ARMED)) || (timeout && !try_last);

   assign pos_clr  = start_frame;
   assign pos_inc  = smp_en && (st_q == ST_SEND) && !pos_last;
   assign wait_clr = smp_en && (st_q == ST_SEND) && pos_last;
   assign wait_inc = win_edge && !ack_in && !wait_last;
   assign try_clr  = accept;
   assign try_inc  = timeout && !try_last;

   always_comb begin
      st_d   = st_q;
      fail_d = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) st_d = ST_ARMED;
         end
         ST_ARMED: begin
            if (smp_en) st_d = ST_SEND;
         end
         ST_SEND: begin
            if (smp_en && pos_last) st_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (acked) begin
               st_d = ST_IDLE;
            end else if (timeout) begin
               if (try_last) begin
                  st_d   = ST_IDLE;
                  fail_d = 1'b1;
               end else begin
                  st_d = ST_SEND;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      if (start_frame || pos_inc) line_d = sample_bit;
      else                        line_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         line_out <= 1'b0;
         fail     <= 1'b0;
      end else begin
         st_q <= st_d;
         fail <= fail_d;
         if (smp_en) line_out <= line_d;
      end
   end

endmodule

// File: rtl/oframe_tx.sv
module oframe_tx
   import oftx_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int START_SAMPLES   = 8,
   parameter int SAMPLES_PER_BIT = 4,
   parameter int ACK_WINDOW      = 4,
   parameter int MAX_ATTEMPTS    = 8,
   parameter bit LSB_FIRST       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              ack_in,
   output logic              line_out,
   output logic              busy,
   output logic              fail
);

   localparam int FRAME_LEN = frame_samples(START_SAMPLES, DATA_W, SAMPLES_PER_BIT);
   localparam int POS_W     = $clog2(FRAME_LEN + 1);
   localparam int WAIT_W    = (ACK_WINDOW > 1) ? $clog2(ACK_WINDOW) : 1;
   localparam int TRY_W     = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;

   if (DATA_W < 1) begin : g_chk_data_w
      initial $fatal(1, "oframe_tx: DATA_W must be at least 1");
   end
   if (START_SAMPLES < 1) begin : g_chk_start
      initial $fatal(1, "oframe_tx: START_SAMPLES must be at least 1");
   end
   if (SAMPLES_PER_BIT < 1) begin : g_chk_spb
      initial $fatal(1, "oframe_tx: SAMPLES_PER_BIT must be at least 1");
   end
   if (ACK_WINDOW < 1) begin : g_chk_window
      initial $fatal(1, "oframe_tx: ACK_WINDOW must be at least 1");
   end
   if (MAX_ATTEMPTS < 1) begin : g_chk_tries
      initial $fatal(1, "oframe_tx: MAX_ATTEMPTS must be at least 1");
   end

   logic [DATA_W-1:0] byte_q;
   logic [POS_W-1:0]  pos_q;
   logic [POS_W-1:0]  idx;
   logic [WAIT_W-1:0] wait_q;
   logic [TRY_W-1:0]  try_q;
   logic pos_last, wait_last, try_last;
   logic accept, start_frame, sample_bit;
   logic pos_clr, pos_inc, wait_clr, wait_inc, try_clr, try_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byte_q <= '0;
      else if (accept) byte_q <= in_data;
   end

   assign pos_last  = (pos_q == POS_W'(FRAME_LEN - 1));
   assign wait_last = (wait_q == WAIT_W'(ACK_WINDOW - 1));
   assign try_last  = (try_q == TRY_W'(MAX_ATTEMPTS - 1));
   assign idx       = start_frame ? '0 : (pos_q + POS_W'(1));

   oftx_step_counter #(.LIMIT(FRAME_LEN), .W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .clr(pos_clr), .inc(pos_inc), .value(pos_q)
   );

   oftx_step_counter #(.LIMIT(ACK_WINDOW), .W(WAIT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .clr(wait_clr), .inc(wait_inc), .value(wait_q)
   );

   oftx_step_counter #(.LIMIT(MAX_ATTEMPTS), .W(TRY_W)) u_try (
      .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .value(try_q)
   );

   oftx_sample_mux #(
      .DATA_W(DATA_W), .START_SAMPLES(START_SAMPLES), .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
      .LSB_FIRST(LSB_FIRST), .POS_W(POS_W)
   ) u_mux (
      .idx(idx), .data(byte_q), .sample(sample_bit)
   );

   oftx_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .in_valid(in_valid), .ack_in(ack_in),
      .pos_last(pos_last), .wait_last(wait_last), .try_last(try_last),
      .sample_bit(sample_bit), .accept(accept), .start_frame(start_frame),
      .pos_clr(pos_clr), .pos_inc(pos_inc), .wait_clr(wait_clr), .wait_inc(wait_inc),
      .try_clr(try_clr), .try_inc(try_inc), .in_ready(in_ready), .busy(busy),
      .line_out(line_out), .fail(fail)
   );

endmodule

// File: rtl/oframe_tx_checker.sv
module oframe_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic smp_en,
   input logic in_valid,
   input logic in_ready,
   input logic ack_in,
   input logic line_out,
   input logic busy,
   input logic fail
);

   AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !line_out); // R1
   AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> (busy && !in_ready)); // R2
   AST_LINE_MOVES_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> $stable(line_out)); // R3
   AST_FAIL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fail |=> !fail); // R10
   AST_FAIL_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) fail |-> (in_ready && !busy)); // R10
   AST_FAIL_ONLY_UNACKED: assert property (@(posedge clk) disable iff (!rst_n) fail |-> (!$past(ack_in) && $past(smp_en))); // R11

endmodule

bind oframe_tx oframe_tx_checker u_oframe_tx_checker (
   .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .in_valid(in_valid), .in_ready(in_ready),
   .ack_in(ack_in), .line_out(line_out), .busy(busy), .fail(fail)
);

// File: tb/oframe_tx_bench.sv
module oframe_tx_bench;

   localparam int DW  = 8;
   localparam int SL  = 8;
   localparam int SPB = 4;
   localparam int AW  = 4;
   localparam int MT  = 8;
   localparam int FL  = SL + DW * SPB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_en = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_valid = 1'b0;
   logic          ack_in = 1'b0;
   logic          in_ready, line_out, busy, fail;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   oframe_tx u_oframe_tx (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .ack_in(ack_in), .line_out(line_out), .busy(busy), .fail(fail)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_sample(logic [DW-1:0] d, int s);
      if (s < SL) return 1;
      return int'(d[(s - SL) / SPB]);
   endfunction

   // three quiet cycles, then one enable edge; returns half a clock after that edge
   task automatic tick();
      repeat (3) @(negedge clk);
      smp_en = 1'b1;
      @(negedge clk);
      smp_en = 1'b0;
   endtask

   task automatic accept_byte(logic [DW-1:0] d);
      chk("R2", "in_ready before offer", int'(in_ready), 1);
      in_data  = d;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "busy after accept", int'(busy), 1);
      chk("R2", "in_ready after accept", int'(in_ready), 0);
      repeat (2) @(negedge clk);
      chk("R3", "line before first enable", int'(line_out), 0);
   endtask

   task automatic transfer(logic [DW-1:0] d, int nacks, int slot, bit ack_in_send, bit poke);
      accept_byte(d);
      tick();
      chk("R4", "first start sample", int'(line_out), 1);
      for (int a = 0; a < MT; a++) begin
         for (int s = 1; s < FL; s++) begin
            ack_in = ack_in_send;
            tick();
            chk((s < SL) ? "R4" : "R5", $sformatf("attempt %0d sample %0d", a, s),
                int'(line_out), exp_sample(d, s));
            if (poke && s == 10) begin
               in_data  = ~d;
               in_valid = 1'b1;
               @(negedge clk);
               chk("R2", "in_ready while sending", int'(in_ready), 0);
               in_valid = 1'b0;
               in_data  = d;
            end
         end
         ack_in = ack_in_send;
         tick();
         ack_in = 1'b0;
         chk("R6", "line after frame", int'(line_out), 0);
         chk("R8", "busy after ack during frame", int'(busy), 1);
         for (int j = 0; j < AW; j++) begin
            bit give;
            give   = (a >= nacks) && (j == slot);
            ack_in = give;
            tick();
            ack_in = 1'b0;
            if (give) begin
               chk((a == MT - 1 && j == AW - 1) ? "R11" : "R7", "busy after ack", int'(busy), 0);
               chk("R7", "in_ready after ack", int'(in_ready), 1);
               chk("R11", "no fail on ack", int'(fail), 0);
               chk("R7", "line after ack", int'(line_out), 0);
               return;
            end else if (j == AW - 1) begin
               if (a == MT - 1) begin
                  chk("R10", "fail pulse", int'(fail), 1);
                  chk("R10", "busy after drop", int'(busy), 0);
                  @(negedge clk);
                  chk("R10", "fail one cycle", int'(fail), 0);
                  return;
               end else begin
                  chk("R9", "resend start sample", int'(line_out), 1);
                  chk("R9", "busy on resend", int'(busy), 1);
               end
            end else begin
               chk("R6", "line in window", int'(line_out), 0);
               chk("R6", "busy in window", int'(busy), 1);
            end
         end
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "line in reset", int'(line_out), 0);
      chk("R1", "in_ready in reset", int'(in_ready), 1);
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "fail in reset", int'(fail), 0);
      rst_n = 1'b1;
      tick();
      chk("R1", "line idle enable", int'(line_out), 0);
      ack_in = 1'b1;
      tick();
      ack_in = 1'b0;
      chk("R8", "busy after idle ack", int'(busy), 0);
      chk("R8", "line after idle ack", int'(line_out), 0);
   endtask

   task automatic t_quiet_after();
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R2", "no stray frame line", int'(line_out), 0);
         chk("R2", "no stray frame busy", int'(busy), 0);
      end
   endtask

   initial begin
      t_reset();
      transfer(8'h1C, 0, 0, 1'b0, 1'b0);   // scan code, ack on first window enable
      transfer(8'hA5, 0, 3, 1'b0, 1'b0);   // ack on last window enable
      transfer(8'h5A, 2, 1, 1'b0, 1'b0);   // two unanswered attempts, then ack
      transfer(8'hC3, 0, 2, 1'b1, 1'b0);   // ack held during the frame is ignored
      transfer(8'h81, 0, 0, 1'b0, 1'b1);   // offer while busy is ignored
      t_quiet_after();
      transfer(8'h3C, MT, 0, 1'b0, 1'b0);  // never acked: fail
      transfer(8'hF0, MT - 1, 3, 1'b0, 1'b0); // ack on last enable of last attempt
      transfer(8'h1C, 0, 1, 1'b0, 1'b0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule